// File: doc/BRIEF.md
# Compare-Driven Output Flag Generator

This block turns timer events into the single output flag of a counter channel and drives it onto the channel pin. It watches strobes from the counter (a match against the first compare value, a match against the second compare value, a counter rollover and an edge on the secondary input), a level that says the counter is active, and the count-source clock. A 3-bit output mode, held in a register inside the block, selects how these events set, clear or toggle the flag. The mode can also pass the count clock straight to the pin.

Software can overwrite the flag at any time by pulsing a force strobe together with the value to load. A polarity input inverts the result just before the pin. An output-enable input decides whether the pin is driven or is left as an input. The mode register is written with a one-cycle strobe. The same write puts the alternating-compare tracker back to its start state.

The events themselves, the counter and any debug-time override are generated outside this block.

Top module: `cmp_flag_out`

## Requirements
- R1: While reset is applied, and until the reset has been released through the synchronizer, the flag is 0, the mode is `RST_MODE`, and the alternating tracker waits for a compare-1 match.
- R2: In mode 3'b000, the pin value before polarity equals `cnt_active_i` in the same cycle.
- R3: Modes 3'b001, 3'b010 and 3'b011 clear, set and toggle the flag at the clock edge that samples a compare strobe, where a compare strobe is either `cmp1_hit_i` or `cmp2_hit_i`. With no compare strobe the flag holds.
- R4: Mode 3'b100 toggles the flag only on the match the tracker expects. It starts by expecting compare 1 and then alternates between compare 1 and compare 2. A match on the other compare does nothing. When both strobes arrive in one cycle, only the expected one counts.
- R5: Mode 3'b101 sets the flag on a compare strobe and clears it on `sec_edge_i`. A compare strobe in the same cycle wins.
- R6: Mode 3'b110 sets the flag on a compare strobe and clears it on `rollover_i`. A compare strobe in the same cycle wins.
- R7: In mode 3'b111, the pin value before polarity is `cnt_clk_i` while `cnt_active_i` is 1, and 0 otherwise.
- R8: A `force_wr_i` pulse loads `force_val_i` into the flag at the next edge, taking priority over any event in that cycle. In modes 3'b000 and 3'b111 the forced value is stored but only becomes visible after a change to a flag-driven mode.
- R9: `pin_o` is the pre-polarity value XOR `pol_inv_i`. `pin_oe_o` follows `oe_i` in the same cycle.
- R10: A `mode_wr_i` pulse stores `mode_i` at the next edge, so the new mode governs from the following cycle on. It also returns the tracker to expecting compare 1, overriding any tracker step in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_clk_i | input | 1 | Count-source clock, gated to the pin in mode 3'b111 |
| cnt_active_i | input | 1 | Counter is running |
| cmp1_hit_i | input | 1 | Match strobe for compare value 1 |
| cmp2_hit_i | input | 1 | Match strobe for compare value 2 |
| rollover_i | input | 1 | Counter rollover strobe |
| sec_edge_i | input | 1 | Secondary-input edge strobe |
| mode_wr_i | input | 1 | Output-mode write strobe |
| mode_i | input | 3 | Output mode written on `mode_wr_i` |
| force_wr_i | input | 1 | Software force strobe |
| force_val_i | input | 1 | Value loaded into the flag on a force |
| pol_inv_i | input | 1 | Invert the flag before the pin |
| oe_i | input | 1 | Drive the pin when 1 |
| pin_o | output | 1 | Pin output value |
| pin_oe_o | output | 1 | Pin output enable |

## Verification
The bench builds the block with its default parameters: reset mode 3'b000 and a two-stage reset synchronizer. The two reset-release cycles are therefore visible and are checked against the reference model. With these defaults, every mode can be reached through the mode-write strobe. The directed cases cover force-against-compare collisions, both compare strobes arriving together in alternating mode, and a mode rewrite in the middle of an alternation. A long random phase then mixes all strobes, random mode writes and polarity changes.

// File: rtl/flag_out_pkg.sv
package flag_out_pkg;

  typedef enum logic [2:0] {
    OM_ACTIVE   = 3'b000,
    OM_CLR      = 3'b001,
    OM_SET      = 3'b010,
    OM_TGL      = 3'b011,
    OM_ALT      = 3'b100,
    OM_SET_SEC  = 3'b101,
    OM_SET_ROLL = 3'b110,
    OM_GATED    = 3'b111
  } omode_e;

  localparam int unsigned OMODE_W = 3;

endpackage

// File: rtl/flag_rst_sync.sv
module flag_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[LAST-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[LAST];

endmodule

// File: rtl/alt_cmp_tracker.sv
module alt_cmp_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  input  logic cmp1_i,
  input  logic cmp2_i,
  output logic hit_o,
  output logic expect2_o
);

  logic expect2_q;
  logic expect2_d;
  logic step_1;
  logic step_2;
  logic upd_en;

  always_comb begin
    step_1    = en_i && !expect2_q && cmp1_i;
    step_2    = en_i &&  expect2_q && cmp2_i;
    hit_o     = step_1 || step_2;
    expect2_d = expect2_q;
    if (clr_i)       expect2_d = 1'b0;
    else if (step_1) expect2_d = 1'b1;
    else if (step_2) expect2_d = 1'b0;
    upd_en    = clr_i || hit_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      expect2_q <= 1'b0;
    else if (upd_en) expect2_q <= expect2_d;
  end

  assign expect2_o = expect2_q;

endmodule

// File: rtl/flag_core.sv
module flag_core
  import flag_out_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  omode_e mode_i,
  input  logic   cmp_any_i,
  input  logic   alt_hit_i,
  input  logic   sec_edge_i,
  input  logic   rollover_i,
  input  logic   force_wr_i,
  input  logic   force_val_i,
  output logic   flag_o
);

  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_d  = flag_q;
    flag_en = 1'b0;
    if (force_wr_i) begin
      flag_d  = force_val_i;
      flag_en = 1'b1;
    end else begin
      case (mode_i)
        OM_CLR: if (cmp_any_i) begin
          flag_d  = 1'b0;
          flag_en = 1'b1;
        end
        OM_SET: if (cmp_any_i) begin
          flag_d  = 1'b1;
          flag_en = 1'b1;
        end
        OM_TGL: if (cmp_any_i) begin
          flag_d  = ~flag_q;
          flag_en = 1'b1;
        end
        OM_ALT: if (alt_hit_i) begin
          flag_d  = ~flag_q;
          flag_en = 1'b1;
        end
        OM_SET_SEC: begin
          if (cmp_any_i) begin
            flag_d  = 1'b1;
            flag_en = 1'b1;
          end else if (sec_edge_i) begin
            flag_d  = 1'b0;
            flag_en = 1'b1;
          end
        end
        OM_SET_ROLL: begin
          if (cmp_any_i) begin
            flag_d  = 1'b1;
            flag_en = 1'b1;
          end else if (rollover_i) begin
            flag_d  = 1'b0;
            flag_en = 1'b1;
          end
        end
        default: begin
          flag_d  = flag_q;
          flag_en = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/flag_pin_stage.sv
module flag_pin_stage
  import flag_out_pkg::*;
(
  input  omode_e mode_i,
  input  logic   flag_i,
  input  logic   cnt_active_i,
  input  logic   cnt_clk_i,
  input  logic   pol_inv_i,
  input  logic   oe_i,
  output logic   pin_o,
  output logic   pin_oe_o
);

  logic raw;

  always_comb begin
    case (mode_i)
      OM_ACTIVE: raw = cnt_active_i;
      OM_GATED:  raw = cnt_active_i & cnt_clk_i;
      default:   raw = flag_i;
    endcase
    pin_o    = raw ^ pol_inv_i;
    pin_oe_o = oe_i;
  end

endmodule

// File: rtl/cmp_flag_out.sv
module cmp_flag_out
  import flag_out_pkg::*;
#(
  parameter logic [2:0]  RST_MODE    = 3'b000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_clk_i,
  input  logic       cnt_active_i,
  input  logic       cmp1_hit_i,
  input  logic       cmp2_hit_i,
  input  logic       rollover_i,
  input  logic       sec_edge_i,
  input  logic       mode_wr_i,
  input  logic [2:0] mode_i,
  input  logic       force_wr_i,
  input  logic       force_val_i,
  input  logic       pol_inv_i,
  input  logic       oe_i,
  output logic       pin_o,
  output logic       pin_oe_o
);

  localparam omode_e MODE_AT_RST = omode_e'(RST_MODE);

  logic   rst_n_sync;
  omode_e mode_q;
  omode_e mode_d;
  logic   cmp_any;
  logic   alt_en;
  logic   alt_hit;
  logic   expect2_q;
  logic   flag_q;

  flag_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_sync)
  );

  always_comb begin
    mode_d  = mode_wr_i ? omode_e'(mode_i) : mode_q;
    cmp_any = cmp1_hit_i || cmp2_hit_i;
    alt_en  = (mode_q == OM_ALT);
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)    mode_q <= MODE_AT_RST;
    else if (mode_wr_i) mode_q <= mode_d;
  end

  alt_cmp_tracker u_track (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .clr_i     (mode_wr_i),
    .en_i      (alt_en),
    .cmp1_i    (cmp1_hit_i),
    .cmp2_i    (cmp2_hit_i),
    .hit_o     (alt_hit),
    .expect2_o (expect2_q)
  );

  flag_core u_core (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .mode_i      (mode_q),
    .cmp_any_i   (cmp_any),
    .alt_hit_i   (alt_hit),
    .sec_edge_i  (sec_edge_i),
    .rollover_i  (rollover_i),
    .force_wr_i  (force_wr_i),
    .force_val_i (force_val_i),
    .flag_o      (flag_q)
  );

  flag_pin_stage u_pin (
    .mode_i       (mode_q),
    .flag_i       (flag_q),
    .cnt_active_i (cnt_active_i),
    .cnt_clk_i    (cnt_clk_i),
    .pol_inv_i    (pol_inv_i),
    .oe_i         (oe_i),
    .pin_o        (pin_o),
    .pin_oe_o     (pin_oe_o)
  );

endmodule

// File: rtl/cmp_flag_out_chk.sv
module cmp_flag_out_chk
  import flag_out_pkg::*;
(
  input logic   clk,
  input logic   rst_n_sync,
  input omode_e mode_q,
  input logic   flag_q,
  input logic   expect2_q,
  input logic   cmp1_hit_i,
  input logic   cmp2_hit_i,
  input logic   rollover_i,
  input logic   sec_edge_i,
  input logic   mode_wr_i,
  input logic   force_wr_i,
  input logic   force_val_i,
  input logic   cnt_active_i,
  input logic   pol_inv_i,
  input logic   pin_o
);

  logic any_cmp;
  assign any_cmp = cmp1_hit_i || cmp2_hit_i;

  p_active_r2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (mode_q == OM_ACTIVE) |-> (pin_o == (cnt_active_i ^ pol_inv_i)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (mode_q == OM_CLR && any_cmp && !force_wr_i) |=> !flag_q);

  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (mode_q == OM_SET && any_cmp && !force_wr_i) |=> flag_q);

  p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (mode_q == OM_TGL && any_cmp && !force_wr_i) |=> (flag_q != $past(flag_q)));

  p_alt_step_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (mode_q == OM_ALT && !expect2_q && cmp1_hit_i && !mode_wr_i) |=> expect2_q);

  p_sec_clear_r5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (mode_q == OM_SET_SEC && sec_edge_i && !any_cmp && !force_wr_i) |=> !flag_q);

  p_roll_clear_r6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (mode_q == OM_SET_ROLL && rollover_i && !any_cmp && !force_wr_i) |=> !flag_q);

  p_gated_low_r7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (mode_q == OM_GATED && !cnt_active_i) |-> (pin_o == pol_inv_i));

  p_force_r8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    force_wr_i |=> (flag_q == $past(force_val_i)));

  p_track_clr_r10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    mode_wr_i |=> !expect2_q);

endmodule

bind cmp_flag_out cmp_flag_out_chk u_chk (
  .clk          (clk),
  .rst_n_sync   (rst_n_sync),
  .mode_q       (mode_q),
  .flag_q       (flag_q),
  .expect2_q    (expect2_q),
  .cmp1_hit_i   (cmp1_hit_i),
  .cmp2_hit_i   (cmp2_hit_i),
  .rollover_i   (rollover_i),
  .sec_edge_i   (sec_edge_i),
  .mode_wr_i    (mode_wr_i),
  .force_wr_i   (force_wr_i),
  .force_val_i  (force_val_i),
  .cnt_active_i (cnt_active_i),
  .pol_inv_i    (pol_inv_i),
  .pin_o        (pin_o)
);

// File: tb/tb_cmp_flag_out.sv
`timescale 1ns/1ps
module tb_cmp_flag_out;

  logic clk;
  logic rst_n;
  logic cclk, act, c1, c2, roll, sec, mwr, fwr, fval, pol, oe;
  logic [2:0] mdat;
  logic pin_o, pin_oe_o;

  int checks;
  int fails;
  bit done;

  int m_mode, m_flag, m_e2, rel;

  cmp_flag_out dut (
    .clk(clk), .rst_n(rst_n), .cnt_clk_i(cclk), .cnt_active_i(act),
    .cmp1_hit_i(c1), .cmp2_hit_i(c2), .rollover_i(roll), .sec_edge_i(sec),
    .mode_wr_i(mwr), .mode_i(mdat), .force_wr_i(fwr), .force_val_i(fval),
    .pol_inv_i(pol), .oe_i(oe), .pin_o(pin_o), .pin_oe_o(pin_oe_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic string tag_of(int m);
    case (m)
      0: return "R2";
      1, 2, 3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic exp_pin();
    int raw;
    if (m_mode == 0)      raw = act;
    else if (m_mode == 7) raw = act & cclk;
    else                  raw = m_flag;
    return logic'(raw[0] ^ pol);
  endfunction

  task automatic check_outputs();
    string t;
    logic e;
    if (!rst_n || rel < 2) t = "R1";
    else if (fwr)          t = "R8";
    else if (mwr)          t = "R10";
    else                   t = tag_of(m_mode);
    e = exp_pin();
    checks++;
    if (pin_o !== e) begin
      fails++;
      $display("FAIL %s pin_o actual=%b expected=%b mode=%0d t=%0t", t, pin_o, e, m_mode, $time);
    end
    checks++;
    if (pin_oe_o !== oe) begin
      fails++;
      $display("FAIL R9 pin_oe_o actual=%b expected=%b t=%0t", pin_oe_o, oe, $time);
    end
  endtask

  task automatic model_edge();
    int hit, alt;
    if (!rst_n) begin
      rel = 0; m_mode = 0; m_flag = 0; m_e2 = 0;
      return;
    end
    if (rel < 2) begin
      rel++; m_mode = 0; m_flag = 0; m_e2 = 0;
      return;
    end
    hit = c1 || c2;
    alt = (m_mode == 4) && ((!m_e2 && c1) || (m_e2 && c2));
    if (fwr) m_flag = fval;
    else begin
      case (m_mode)
        1: if (hit) m_flag = 0;
        2: if (hit) m_flag = 1;
        3: if (hit) m_flag = 1 - m_flag;
        4: if (alt) m_flag = 1 - m_flag;
        5: if (hit) m_flag = 1; else if (sec) m_flag = 0;
        6: if (hit) m_flag = 1; else if (roll) m_flag = 0;
        default: ;
      endcase
    end
    if (mwr)      m_e2 = 0;
    else if (alt) m_e2 = 1 - m_e2;
    if (mwr) m_mode = mdat;
  endtask

  task automatic tick();
    #1;
    check_outputs();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    c1 = 0; c2 = 0; roll = 0; sec = 0; mwr = 0; fwr = 0;
  endtask

  task automatic set_mode(input logic [2:0] m);
    mwr = 1; mdat = m;
    tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 0;
    rel = 0; m_mode = 0; m_flag = 0; m_e2 = 0;
    rst_n = 0; cclk = 0; act = 0; c1 = 0; c2 = 0; roll = 0; sec = 0;
    mwr = 0; mdat = 0; fwr = 0; fval = 0; pol = 0; oe = 0;
    @(negedge clk);
    // R1: reset state, including synchronizer release cycles
    idle(3);
    rst_n = 1;
    idle(3);

    // R2: counter-active level drives the pin
    act = 1; tick(); act = 0; tick(); act = 1; pol = 1; tick(); pol = 0; act = 0; tick();

    // R3: clear / set / toggle
    set_mode(3'b010); idle(1);
    c1 = 1; tick(); idle(1);
    set_mode(3'b001); c2 = 1; tick(); idle(1);
    set_mode(3'b011); c1 = 1; tick(); c2 = 1; tick(); c1 = 1; c2 = 1; tick(); idle(2);

    // R4: alternating compares, wrong one ignored, both together
    set_mode(3'b100);
    c2 = 1; tick(); c1 = 1; tick(); c1 = 1; tick(); c2 = 1; tick();
    c1 = 1; c2 = 1; tick(); c1 = 1; c2 = 1; tick(); idle(1);
    // R10: rewrite mode mid-alternation restarts at compare 1
    c1 = 1; tick();
    set_mode(3'b100); c2 = 1; tick(); c1 = 1; tick(); idle(1);
    c1 = 1; mwr = 1; mdat = 3'b100; tick(); c2 = 1; tick(); idle(1);

    // R5: set on compare, clear on secondary edge, compare wins
    set_mode(3'b101); c1 = 1; tick(); sec = 1; tick(); c2 = 1; sec = 1; tick(); sec = 1; tick();

    // R6: set on compare, clear on rollover, compare wins
    set_mode(3'b110); c1 = 1; tick(); roll = 1; tick(); c1 = 1; roll = 1; tick(); roll = 1; tick();

    // R7: gated count clock
    set_mode(3'b111);
    for (int i = 0; i < 8; i++) begin cclk = i[0]; act = (i > 2 && i < 7); tick(); end
    cclk = 1; act = 0; tick();

    // R8: force beats compare; force hidden in mode 000 until mode change
    set_mode(3'b010); fwr = 1; fval = 0; c1 = 1; tick(); idle(1);
    fwr = 1; fval = 1; tick(); fwr = 1; fval = 0; tick();
    set_mode(3'b000); act = 0; fwr = 1; fval = 1; tick(); idle(1);
    set_mode(3'b001); idle(2);

    // R9: polarity and output enable
    pol = 1; oe = 1; tick(); oe = 0; tick(); pol = 0; oe = 1; tick();

    // random mix over all modes
    for (int i = 0; i < 600; i++) begin
      c1 = ($urandom_range(0, 3) == 0);
      c2 = ($urandom_range(0, 3) == 0);
      roll = ($urandom_range(0, 4) == 0);
      sec = ($urandom_range(0, 4) == 0);
      act = $urandom_range(0, 1);
      cclk = $urandom_range(0, 1);
      pol = ($urandom_range(0, 9) == 0) ? ~pol : pol;
      oe = $urandom_range(0, 1);
      fwr = ($urandom_range(0, 15) == 0);
      fval = $urandom_range(0, 1);
      if ($urandom_range(0, 11) == 0) begin mwr = 1; mdat = 3'($urandom_range(0, 7)); end
      tick();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule